// File: doc/BRIEF.md
# Seconds and Sub-Second Timebase

This block keeps two free-running elapsed-time counters for a register bank to read. A sub-second counter follows a 25 MHz cycle count, but it moves only on a strobe that marks each 640 ns interval. On each strobe it advances by sixteen, so its four low bits never change from zero. When the next value would reach 25,000,000 it returns to zero, which happens once per second. A seconds counter counts those returns.

The strobe is produced outside the block as a single-cycle enable in the system clock domain. Both counters are registers and change on the same clock edge, so a read in any cycle sees a matching pair. A preload input forces the sub-second counter to a chosen value, which lets a test approach the wrap point without a full second of strobes. A cold reset clears both counters.

Top module: `sec_timebase`

## Requirements
- R1: While rst_n is low, both subsec_o and seconds_o read zero on the following clock edge.
- R2: A cycle with tick high and preload_en low adds 16 to subsec_o. Bits 3:0 of subsec_o always read zero.
- R3: When subsec_o plus 16 would equal or exceed 25,000,000, a tick sets subsec_o to zero instead, so subsec_o never exceeds 24,999,984.
- R4: The tick that makes subsec_o return to zero also adds one to seconds_o in the same clock edge. seconds_o changes on no other cycle and wraps modulo 2^32.
- R5: In a cycle with tick and preload_en both low, neither output changes.
- R6: When preload_en is high, subsec_o takes preload_val with bits 3:0 forced to zero. If that value is 25,000,000 or more, subsec_o takes zero. A preload has priority over a tick in the same cycle and leaves seconds_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous cold reset |
| tick | input | 1 | Single-cycle strobe, once per 640 ns interval |
| preload_en | input | 1 | Force the sub-second counter this cycle |
| preload_val | input | 32 | Value used by preload_en |
| subsec_o | output | 32 | Sub-second count of 25 MHz cycles, in steps of 16 |
| seconds_o | output | 32 | Whole seconds since cold reset |

## Verification
The checker assumes that the two counters start from their reset values and that preload only ever leaves the sub-second counter aligned and below the wrap limit. The block enforces this on every path, so the step, hold and wrap properties cover every cycle after reset. The stimulus strobes tick in irregular gaps, sometimes on consecutive cycles. It preloads values at and just below the wrap point, unaligned values and out-of-range values, and it drives preload together with tick. The bench model works with a running total split by division and remainder, not with a comparison against the limit.

// File: rtl/sec_timebase_pkg.sv
package sec_timebase_pkg;

  localparam int unsigned CNT_W = 32;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic carry;
    cnt_t val;
  } adv_t;

  // next sub-second value for one strobe, with wrap flag
  function automatic adv_t sub_advance(cnt_t cur, cnt_t step, cnt_t wrap);
    adv_t r;
    logic [CNT_W:0] sum;
    sum = {1'b0, cur} + {1'b0, step};
    if (sum >= {1'b0, wrap}) begin
      r.carry = 1'b1;
      r.val   = '0;
    end else begin
      r.carry = 1'b0;
      r.val   = sum[CNT_W-1:0];
    end
    return r;
  endfunction

  // align a preload value to the step and clamp out-of-range to zero
  function automatic cnt_t align_load(cnt_t v, cnt_t step, cnt_t wrap);
    cnt_t a;
    a = v & ~(step - cnt_t'(1));
    return (a >= wrap) ? '0 : a;
  endfunction

endpackage

// File: rtl/tb_subsec_cnt.sv
module tb_subsec_cnt
  import sec_timebase_pkg::*;
#(
  parameter int unsigned STEP = 16,
  parameter int unsigned WRAP = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ld,
  input  cnt_t ld_val,
  output cnt_t sub_q,
  output logic wrap_o
);

  localparam cnt_t STEP_C = cnt_t'(STEP);
  localparam cnt_t WRAP_C = cnt_t'(WRAP);

  adv_t adv;
  cnt_t ld_aligned;

  always_comb begin
    adv        = sub_advance(sub_q, STEP_C, WRAP_C);
    ld_aligned = align_load(ld_val, STEP_C, WRAP_C);
    wrap_o     = tick & ~ld & adv.carry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    sub_q <= '0;
    else if (ld)   sub_q <= ld_aligned;
    else if (tick) sub_q <= adv.val;
  end

endmodule

// File: rtl/tb_sec_cnt.sv
module tb_sec_cnt
  import sec_timebase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output cnt_t sec_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   sec_q <= '0;
    else if (inc) sec_q <= sec_q + cnt_t'(1);
  end

endmodule

// File: rtl/sec_timebase.sv
module sec_timebase
  import sec_timebase_pkg::*;
#(
  parameter int unsigned STEP = 16,
  parameter int unsigned WRAP = 25_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        preload_en,
  input  logic [31:0] preload_val,
  output logic [31:0] subsec_o,
  output logic [31:0] seconds_o
);

  // one-cycle event: sub-second counter rolls over this edge
  logic wrap_evt;
  cnt_t sub_q;
  cnt_t sec_q;

  tb_subsec_cnt #(.STEP(STEP), .WRAP(WRAP)) u_sub (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .ld     (preload_en),
    .ld_val (preload_val),
    .sub_q  (sub_q),
    .wrap_o (wrap_evt)
  );

  tb_sec_cnt u_sec (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wrap_evt),
    .sec_q (sec_q)
  );

  assign subsec_o  = sub_q;
  assign seconds_o = sec_q;

endmodule

// File: rtl/sec_timebase_chk.sv
module sec_timebase_chk #(
  parameter int unsigned STEP = 16,
  parameter int unsigned WRAP = 25_000_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        preload_en,
  input logic [31:0] subsec_o,
  input logic [31:0] seconds_o,
  input logic        wrap_evt
);

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (subsec_o == 32'd0 && seconds_o == 32'd0)); // R1

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (subsec_o % STEP) == 0); // R2

  AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !preload_en && !wrap_evt) |=> subsec_o == $past(subsec_o) + STEP); // R2

  AST_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    subsec_o < WRAP); // R3

  AST_WRAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (subsec_o == 32'd0 && seconds_o == $past(seconds_o) + 32'd1)); // R4

  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(seconds_o)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !preload_en) |=> $stable(subsec_o)); // R5

  AST_LOAD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |-> !wrap_evt); // R6

endmodule

bind sec_timebase sec_timebase_chk #(.STEP(STEP), .WRAP(WRAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .preload_en (preload_en),
  .subsec_o   (subsec_o),
  .seconds_o  (seconds_o),
  .wrap_evt   (wrap_evt)
);

// File: tb/sim_sec_timebase.sv
module sim_sec_timebase;

  localparam longint LIMIT = 25_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        preload_en = 1'b0;
  logic [31:0] preload_val = '0;
  logic [31:0] subsec_o;
  logic [31:0] seconds_o;

  int errors = 0;
  int checks = 0;
  longint exp_sub = 0;
  longint exp_sec = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sec_timebase u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preload_en(preload_en),
    .preload_val(preload_val), .subsec_o(subsec_o), .seconds_o(seconds_o)
  );

  task automatic check(string req, logic [31:0] got, longint expv);
    checks++;
    if (got !== 32'(expv)) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, 32'(expv));
    end
  endtask

  // one clock: drive, let the edge pass, update model, compare
  task automatic cyc(string req, bit t, bit l, logic [31:0] v);
    longint total;
    tick = t; preload_en = l; preload_val = v;
    @(posedge clk); #1;
    if (l) begin
      total = longint'(v) - (longint'(v) % 16);
      exp_sub = (total < LIMIT) ? total : 0;
    end else if (t) begin
      total = exp_sub + 16;
      exp_sec = (exp_sec + total / LIMIT) % 64'h1_0000_0000;
      exp_sub = total % LIMIT;
    end
    check(req, subsec_o, exp_sub);
    check(req, seconds_o, exp_sec);
    check({req, " low bits R2"}, {28'd0, subsec_o[3:0]}, 0);
    tick = 0; preload_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 subsec reset", subsec_o, 0);
    check("R1 seconds reset", seconds_o, 0);
    rst_n = 1'b1;
    // R5: idle cycles
    for (int i = 0; i < 5; i++) cyc("R5 idle", 0, 0, 0);
    // R2: irregular tick pattern from zero
    for (int i = 0; i < 60; i++) cyc("R2 step", (i % 3) != 1, 0, 0);
    // R3/R4: approach wrap from several offsets, back-to-back ticks
    for (int k = 0; k < 6; k++) begin
      cyc("R6 load near wrap", 0, 1, 32'(LIMIT - 16 * (k + 1)));
      for (int i = 0; i < 9; i++) cyc("R3 R4 wrap", 1, 0, 0);
      cyc("R5 hold after wrap", 0, 0, 0);
    end
    // R6: unaligned, exact-limit and out-of-range preloads
    cyc("R6 unaligned", 0, 1, 32'h0012_3457);
    cyc("R6 exact limit", 0, 1, 32'(LIMIT));
    cyc("R6 over range", 0, 1, 32'hFFFF_FFFF);
    cyc("R6 just below", 0, 1, 32'(LIMIT - 1));
    // R6: preload beats tick, even at the wrap point
    cyc("R6 load", 0, 1, 32'(LIMIT - 16));
    cyc("R6 load with tick", 1, 1, 32'(LIMIT - 16));
    cyc("R6 load with tick mid", 1, 1, 32'd4096);
    cyc("R2 after load", 1, 0, 0);
    // R5: idle with a preload value present but not enabled
    preload_val = 32'd777;
    for (int i = 0; i < 4; i++) cyc("R5 idle with value", 0, 0, 32'd777);
    // R1: reset mid-run clears both
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 subsec re-reset", subsec_o, 0);
    check("R1 seconds re-reset", seconds_o, 0);
    exp_sub = 0; exp_sec = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) cyc("R2 after reset", 1, 0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule